// File: doc/BRIEF.md
# SD Command Issue Controller

This block sits between the register file of an SD host controller and its card-side command engine. Software writes a combined 32-bit word whose low half is a transfer-mode register and whose high half is a command register, plus a separate 32-bit argument register. Both writes are byte-masked. A command starts only when the write covers the top byte of the combined word and the issue rules allow it. The block then presents the command index and the argument to the card side and holds them until a response arrives.

When the response arrives, the block stores a 4-byte answer in response register 0. It raises one-cycle completion pulses and releases the command-inhibit flag. If the command carries data and a block size is programmed, it emits a pulse that starts the data phase and clears the data byte counter. After a multi-block transfer ends with the automatic-stop mode bit set, the block issues a stop command (index 12, argument 0) by itself. It routes that command's response to response register 3.

Top module: `sdcmd_issue_ctrl`

## Requirements
- R1: A launched command presents bits 15:8 of the command register as `cmd_idx` and the argument register as `cmd_arg`, with `cmd_req` high.
- R2: A write with `wr_sel`=0 launches a command only when `wr_be[3]` is set. A write that leaves `wr_be[3]` clear updates only the bytes it enables and starts nothing.
- R3: Every write to the transfer-mode half keeps only the bits of mask 0x0037. When `dma_cap` is low, bit 0 (the DMA enable) is also forced to 0.
- R4: No command launches while `sd_clk_on` is low.
- R5: While `data_inhibit` or `gap_stop` is high, a command is refused if it has data present (command bit 5) or if its response type (command bits 1:0) is 3, meaning 48-bit with busy. Other commands still launch.
- R6: A response of length 4 to a command whose response type is not 0 (none) goes into `rsp0_q`. The first byte received (`rsp_bytes[7:0]`) lands in bits 31:24. Any other length or type leaves `rsp0_q` unchanged.
- R7: A response to a command of type 3 gives a one-cycle `xfer_done` pulse. No other type does.
- R8: A response gives a one-cycle `cmd_done` pulse only if `cmd_cmp_en` was high, and it drops `cmd_inhibit`.
- R9: A response to a data-present command with nonzero `blk_size` gives a one-cycle `data_start` pulse. With `blk_size` of 0 there is no pulse.
- R10: A `xfer_end` pulse while mode bit 5 (multi-block) and bit 2 (auto stop) are both set issues index 12 with argument 0. Its 4-byte response goes to `rsp3_q`, and it leaves `rsp0_q` unchanged and gives no `cmd_done`.
- R11: While a command is in flight or pending, `cmd_inhibit` is high. Further launch writes are refused, and the request outputs stay stable until the response.
- R12: After reset, the registers, the response registers and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: mode/command word, 1: argument |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| dma_cap | input | 1 | Controller advertises DMA |
| sd_clk_on | input | 1 | Card clock running |
| data_inhibit | input | 1 | Data lines in use |
| gap_stop | input | 1 | Transfer held at block gap |
| blk_size | input | 12 | Programmed block size in bytes |
| cmd_cmp_en | input | 1 | Command-complete status enable |
| xfer_end | input | 1 | Pulse: multi-block transfer ended |
| mode_q | output | 16 | Transfer-mode register |
| cmd_q | output | 16 | Command register |
| arg_q | output | 32 | Argument register |
| cmd_req | output | 1 | Command request to card side |
| cmd_idx | output | 8 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response present this cycle |
| rsp_len | input | 5 | Response length in bytes |
| rsp_bytes | input | 32 | Response bytes, first received in bits 7:0 |
| rsp0_q | output | 32 | Response register 0 |
| rsp3_q | output | 32 | Response register 3 (auto stop) |
| cmd_inhibit | output | 1 | Command in flight or pending |
| cmd_done | output | 1 | Pulse: command complete |
| xfer_done | output | 1 | Pulse: transfer complete (busy type) |
| data_start | output | 1 | Pulse: start data phase, clear byte count |

## Verification
The assertions check on every cycle that the request stays stable while a command waits for its answer. They also check that only a launch write moves the sequencer out of idle, that the mode register changes only on a mode write, and that no launch happens with the clock off. They further check that `cmd_done` never fires without its enable and that `rsp3_q` changes only on an automatic stop's response. The bench scenarios are the only place the values themselves are shown. These cover the byte order in `rsp0_q`, the mask and DMA-bit rules, refusals under inhibit and gap stop, and the data-start condition on block size. They also cover the routing of the stop response to register 3 and not register 0.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    localparam logic [15:0] MODE_KEEP = 16'h0037;
    localparam int          MODE_DMA_BIT   = 0;
    localparam int          MODE_AUTO_BIT  = 2;
    localparam int          MODE_MULTI_BIT = 5;
    localparam int          CMD_DATA_BIT   = 5;
    localparam logic [1:0]  RSP_NONE  = 2'd0;
    localparam logic [1:0]  RSP_LONG  = 2'd1;
    localparam logic [1:0]  RSP_SHORT = 2'd2;
    localparam logic [1:0]  RSP_BUSY  = 2'd3;
    localparam logic [7:0]  STOP_IDX  = 8'd12;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SOFT = 2'd1,
        SQ_AUTO = 2'd2
    } seq_e;
endpackage

// File: rtl/sdcmd_regs.sv
module sdcmd_regs
    import sdcmd_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int NB = WORD_W / 8,
    localparam int HW = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NB-1:0]     wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              dma_cap,
    output logic [HW-1:0]     mode_q,
    output logic [HW-1:0]     cmd_q,
    output logic [WORD_W-1:0] arg_q,
    output logic              top_wr_o,
    output logic [HW-1:0]     cmd_nx_o
);
    typedef struct packed {
        logic [HW-1:0]     mode;
        logic [HW-1:0]     cmd;
        logic [WORD_W-1:0] arg;
    } regs_t;

    regs_t r_d, r_q;
    logic [WORD_W-1:0] ctl_old, ctl_mrg, arg_mrg;
    logic [HW-1:0]     mode_mask;

    assign ctl_old = {r_q.cmd, r_q.mode};

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign ctl_mrg[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : ctl_old[8*b +: 8];
        assign arg_mrg[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : r_q.arg[8*b +: 8];
    end

    always_comb begin
        mode_mask = HW'(MODE_KEEP);
        if (!dma_cap) begin
            mode_mask[MODE_DMA_BIT] = 1'b0;
        end
        r_d = r_q;
        if (wr_en && !wr_sel) begin
            r_d.mode = ctl_mrg[HW-1:0] & mode_mask;
            r_d.cmd  = ctl_mrg[WORD_W-1:HW];
        end
        if (wr_en && wr_sel) begin
            r_d.arg = arg_mrg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mode_q   = r_q.mode;
    assign cmd_q    = r_q.cmd;
    assign arg_q    = r_q.arg;
    assign top_wr_o = wr_en && !wr_sel && wr_be[NB-1];
    assign cmd_nx_o = ctl_mrg[WORD_W-1:HW];

    // R3: the mode register moves only on a mode/command write
    p_mode_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.mode) |-> $past(wr_en && !wr_sel));
endmodule

// File: rtl/sdcmd_gate.sv
module sdcmd_gate
    import sdcmd_pkg::*;
(
    input  logic       sd_clk_on,
    input  logic       busy,
    input  logic       data_inhibit,
    input  logic       gap_stop,
    input  logic       nx_data,
    input  logic [1:0] nx_rtype,
    output logic       may_issue
);
    logic lines_held, needs_lines;

    always_comb begin
        lines_held  = data_inhibit || gap_stop;
        needs_lines = nx_data || (nx_rtype == RSP_BUSY);
        may_issue   = sd_clk_on && !busy && !(lines_held && needs_lines);
    end
endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int ARG_W = 32,
    parameter int BLK_W = 12,
    parameter int LEN_W = 5,
    localparam int RB = ARG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [IDX_W-1:0] nx_idx,
    input  logic [1:0]       nx_rtype,
    input  logic             nx_data,
    input  logic [ARG_W-1:0] arg_in,
    input  logic             mode_multi,
    input  logic             mode_auto,
    input  logic [BLK_W-1:0] blk_size,
    input  logic             cmd_cmp_en,
    input  logic             xfer_end,
    input  logic             rsp_valid,
    input  logic [LEN_W-1:0] rsp_len,
    input  logic [ARG_W-1:0] rsp_bytes,
    output logic             cmd_req,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [ARG_W-1:0] cmd_arg,
    output logic [ARG_W-1:0] rsp0_q,
    output logic [ARG_W-1:0] rsp3_q,
    output logic             busy,
    output logic             cmd_done,
    output logic             xfer_done,
    output logic             data_start
);
    typedef struct packed {
        seq_e             st;
        logic             pend;
        logic [IDX_W-1:0] idx;
        logic [ARG_W-1:0] arg;
        logic [1:0]       rtype;
        logic             dpres;
        logic [ARG_W-1:0] rsp0;
        logic [ARG_W-1:0] rsp3;
        logic             cmp;
        logic             xcmp;
        logic             dstart;
    } seq_t;

    seq_t s_d, s_q;
    logic [ARG_W-1:0] rsp_be;
    logic             len_ok;

    // first received byte goes to the most significant lane
    for (genvar k = 0; k < RB; k++) begin : g_swap
        assign rsp_be[8*(RB-1-k) +: 8] = rsp_bytes[8*k +: 8];
    end
    assign len_ok = (rsp_len == LEN_W'(RB));

    always_comb begin
        s_d        = s_q;
        s_d.cmp    = 1'b0;
        s_d.xcmp   = 1'b0;
        s_d.dstart = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (s_q.pend) begin
                    s_d.st   = SQ_AUTO;
                    s_d.pend = 1'b0;
                    s_d.idx  = IDX_W'(STOP_IDX);
                    s_d.arg  = '0;
                end else if (issue) begin
                    s_d.st    = SQ_SOFT;
                    s_d.idx   = nx_idx;
                    s_d.arg   = arg_in;
                    s_d.rtype = nx_rtype;
                    s_d.dpres = nx_data;
                end
            end
            SQ_SOFT: begin
                if (rsp_valid) begin
                    if (s_q.rtype != RSP_NONE && len_ok) s_d.rsp0 = rsp_be;
                    s_d.xcmp   = (s_q.rtype == RSP_BUSY);
                    s_d.cmp    = cmd_cmp_en;
                    s_d.dstart = s_q.dpres && (blk_size != '0);
                    s_d.st     = SQ_IDLE;
                end
            end
            SQ_AUTO: begin
                if (rsp_valid) begin
                    if (len_ok) s_d.rsp3 = rsp_be;
                    s_d.st = SQ_IDLE;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
        if (xfer_end && mode_multi && mode_auto) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmd_req    = (s_q.st != SQ_IDLE);
    assign cmd_idx    = s_q.idx;
    assign cmd_arg    = s_q.arg;
    assign rsp0_q     = s_q.rsp0;
    assign rsp3_q     = s_q.rsp3;
    assign busy       = (s_q.st != SQ_IDLE) || s_q.pend;
    assign cmd_done   = s_q.cmp;
    assign xfer_done  = s_q.xcmp;
    assign data_start = s_q.dstart;

    // R11: request held steady until answered
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SQ_IDLE && !rsp_valid) |=> (cmd_req && $stable(cmd_idx) && $stable(cmd_arg)));
    // R2: software command state entered only through a launch write
    p_soft_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SQ_SOFT && $past(s_q.st) == SQ_IDLE) |-> $past(issue));
    // R8: completion pulse needs its enable
    p_cmp_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $past(cmd_cmp_en));
    // R10: register 3 written only by the automatic stop's answer
    p_rsp3_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rsp3_q) |-> $past(s_q.st == SQ_AUTO && rsp_valid));
endmodule

// File: rtl/sdcmd_issue_ctrl.sv
module sdcmd_issue_ctrl
    import sdcmd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BLK_W  = 12,
    parameter int LEN_W  = 5,
    localparam int NB    = WORD_W / 8,
    localparam int HW    = WORD_W / 2,
    localparam int IDX_W = HW / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NB-1:0]     wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              dma_cap,
    input  logic              sd_clk_on,
    input  logic              data_inhibit,
    input  logic              gap_stop,
    input  logic [BLK_W-1:0]  blk_size,
    input  logic              cmd_cmp_en,
    input  logic              xfer_end,
    output logic [HW-1:0]     mode_q,
    output logic [HW-1:0]     cmd_q,
    output logic [WORD_W-1:0] arg_q,
    output logic              cmd_req,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [WORD_W-1:0] cmd_arg,
    input  logic              rsp_valid,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [WORD_W-1:0] rsp_bytes,
    output logic [WORD_W-1:0] rsp0_q,
    output logic [WORD_W-1:0] rsp3_q,
    output logic              cmd_inhibit,
    output logic              cmd_done,
    output logic              xfer_done,
    output logic              data_start
);
    logic          top_wr, may_issue, issue, busy;
    logic [HW-1:0] cmd_nx;

    sdcmd_regs #(.WORD_W(WORD_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_be(wr_be), .wr_data(wr_data), .dma_cap(dma_cap),
        .mode_q(mode_q), .cmd_q(cmd_q), .arg_q(arg_q),
        .top_wr_o(top_wr), .cmd_nx_o(cmd_nx)
    );

    sdcmd_gate gate_i (
        .sd_clk_on(sd_clk_on), .busy(busy), .data_inhibit(data_inhibit),
        .gap_stop(gap_stop), .nx_data(cmd_nx[CMD_DATA_BIT]),
        .nx_rtype(cmd_nx[1:0]), .may_issue(may_issue)
    );

    assign issue = top_wr && may_issue;

    sdcmd_seq #(.IDX_W(IDX_W), .ARG_W(WORD_W), .BLK_W(BLK_W), .LEN_W(LEN_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .nx_idx(cmd_nx[HW-1:HW-IDX_W]), .nx_rtype(cmd_nx[1:0]),
        .nx_data(cmd_nx[CMD_DATA_BIT]), .arg_in(arg_q),
        .mode_multi(mode_q[MODE_MULTI_BIT]), .mode_auto(mode_q[MODE_AUTO_BIT]),
        .blk_size(blk_size), .cmd_cmp_en(cmd_cmp_en), .xfer_end(xfer_end),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes),
        .cmd_req(cmd_req), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .rsp0_q(rsp0_q), .rsp3_q(rsp3_q), .busy(busy),
        .cmd_done(cmd_done), .xfer_done(xfer_done), .data_start(data_start)
    );

    assign cmd_inhibit = busy;

    // R4: a launch write with the card clock stopped leaves the block idle
    p_clk_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (top_wr && !sd_clk_on && !busy && !xfer_end) |=> !cmd_inhibit);
endmodule

// File: tb/sdcmd_issue_ctrl_tb.sv
module sdcmd_issue_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, wr_sel = 0;
    logic [3:0]  wr_be = 0;
    logic [31:0] wr_data = 0;
    logic        dma_cap = 0, sd_clk_on = 1, data_inhibit = 0, gap_stop = 0;
    logic [11:0] blk_size = 0;
    logic        cmd_cmp_en = 1, xfer_end = 0;
    logic [15:0] mode_q, cmd_q;
    logic [31:0] arg_q, cmd_arg, rsp0_q, rsp3_q;
    logic        cmd_req, cmd_inhibit, cmd_done, xfer_done, data_start;
    logic [7:0]  cmd_idx;
    logic        rsp_valid = 0;
    logic [4:0]  rsp_len = 5'd4;
    logic [31:0] rsp_bytes = 0;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    sdcmd_issue_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .dma_cap(dma_cap), .sd_clk_on(sd_clk_on),
        .data_inhibit(data_inhibit), .gap_stop(gap_stop), .blk_size(blk_size),
        .cmd_cmp_en(cmd_cmp_en), .xfer_end(xfer_end), .mode_q(mode_q),
        .cmd_q(cmd_q), .arg_q(arg_q), .cmd_req(cmd_req), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .rsp_valid(rsp_valid), .rsp_len(rsp_len),
        .rsp_bytes(rsp_bytes), .rsp0_q(rsp0_q), .rsp3_q(rsp3_q),
        .cmd_inhibit(cmd_inhibit), .cmd_done(cmd_done), .xfer_done(xfer_done),
        .data_start(data_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0; wr_be = 0;
    endtask

    task automatic respond(input logic [4:0] len, input logic [31:0] b);
        rsp_valid = 1; rsp_len = len; rsp_bytes = b;
        @(posedge clk); @(negedge clk);
        rsp_valid = 0;
    endtask

    task automatic t_reset;
        check("R12 mode", mode_q, 0);
        check("R12 cmd", cmd_q, 0);
        check("R12 req", cmd_req, 0);
        check("R12 rsp0", rsp0_q, 0);
        check("R12 inhibit", cmd_inhibit, 0);
    endtask

    task automatic t_partial_writes;
        wr(1, 4'hF, 32'hA5A5_1234);
        check("R1 arg reg", arg_q, 32'hA5A5_1234);
        wr(0, 4'b0100, 32'h0002_0000);
        check("R2 low cmd byte", cmd_q, 16'h0002);
        check("R2 no launch", cmd_req, 0);
    endtask

    task automatic t_mode_mask;
        dma_cap = 0; wr(0, 4'b0011, 32'h0000_FFFF);
        check("R3 mask no dma", mode_q, 16'h0036);
        dma_cap = 1; wr(0, 4'b0011, 32'h0000_FFFF);
        check("R3 mask dma", mode_q, 16'h0037);
        check("R2 mode write no launch", cmd_req, 0);
        wr(0, 4'b0011, 32'h0);
    endtask

    task automatic t_launch_short;
        wr(0, 4'b1000, 32'h1100_0000);
        check("R1 req", cmd_req, 1);
        check("R1 idx", cmd_idx, 8'h11);
        check("R1 arg", cmd_arg, 32'hA5A5_1234);
        check("R11 inhibit", cmd_inhibit, 1);
        respond(5'd4, 32'hEFBE_ADDE);
        check("R6 rsp0 order", rsp0_q, 32'hDEAD_BEEF);
        check("R8 cmd_done", cmd_done, 1);
        check("R8 inhibit drop", cmd_inhibit, 0);
        check("R7 no xfer_done", xfer_done, 0);
        @(negedge clk);
        check("R8 pulse one cycle", cmd_done, 0);
    endtask

    task automatic t_busy_type;
        cmd_cmp_en = 0;
        wr(0, 4'b1100, 32'h0703_0000);
        check("R1 idx busy", cmd_idx, 8'h07);
        respond(5'd4, 32'h0403_0201);
        check("R7 xfer_done", xfer_done, 1);
        check("R8 no cmd_done", cmd_done, 0);
        check("R6 rsp0", rsp0_q, 32'h0102_0304);
        cmd_cmp_en = 1;
    endtask

    task automatic t_clock_off;
        sd_clk_on = 0;
        wr(0, 4'b1100, 32'h0902_0000);
        check("R4 refused", cmd_req, 0);
        sd_clk_on = 1;
    endtask

    task automatic t_inhibit_rules;
        gap_stop = 1;
        wr(0, 4'b1100, 32'h0A03_0000);
        check("R5 gap busy refused", cmd_req, 0);
        gap_stop = 0; data_inhibit = 1;
        wr(0, 4'b1100, 32'h0B22_0000);
        check("R5 inhibit data refused", cmd_req, 0);
        wr(0, 4'b1100, 32'h0C02_0000);
        check("R5 plain allowed", cmd_req, 1);
        respond(5'd4, 32'h0);
        data_inhibit = 0;
    endtask

    task automatic t_data_start;
        blk_size = 12'd512;
        wr(0, 4'b1100, 32'h1122_0000);
        respond(5'd4, 32'h1);
        check("R9 data_start", data_start, 1);
        blk_size = 12'd0;
        wr(0, 4'b1100, 32'h1122_0000);
        respond(5'd4, 32'h1);
        check("R9 zero size none", data_start, 0);
    endtask

    task automatic t_other_lengths;
        logic [31:0] keep;
        keep = rsp0_q;
        wr(0, 4'b1100, 32'h0201_0000);
        respond(5'd16, 32'h5555_5555);
        check("R6 long len kept", rsp0_q, keep);
        wr(0, 4'b1100, 32'h0000_0000);
        respond(5'd4, 32'h6666_6666);
        check("R6 none type kept", rsp0_q, keep);
    endtask

    task automatic t_auto_stop;
        logic [31:0] keep;
        keep = rsp0_q;
        wr(0, 4'b0001, 32'h0000_0024);
        xfer_end = 1; @(posedge clk); @(negedge clk); xfer_end = 0;
        check("R10 pending inhibit", cmd_inhibit, 1);
        @(negedge clk);
        check("R10 req", cmd_req, 1);
        check("R10 idx 12", cmd_idx, 8'd12);
        check("R10 arg 0", cmd_arg, 0);
        respond(5'd4, 32'h7856_3412);
        check("R10 rsp3", rsp3_q, 32'h1234_5678);
        check("R10 rsp0 kept", rsp0_q, keep);
        check("R10 no cmd_done", cmd_done, 0);
        wr(0, 4'b0001, 32'h0000_0020);
        xfer_end = 1; @(posedge clk); @(negedge clk); xfer_end = 0;
        @(negedge clk);
        check("R10 no auto without bit2", cmd_req, 0);
    endtask

    task automatic t_in_flight;
        wr(0, 4'b1100, 32'h2102_0000);
        wr(0, 4'b1100, 32'h2202_0000);
        check("R11 idx held", cmd_idx, 8'h21);
        check("R11 still req", cmd_req, 1);
        respond(5'd4, 32'h0);
        @(negedge clk);
        check("R11 idle after", cmd_req, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_partial_writes();
        t_mode_mask();
        t_launch_short();
        t_busy_type();
        t_clock_off();
        t_inhibit_rules();
        t_data_start();
        t_other_lengths();
        t_auto_stop();
        t_in_flight();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule